// File: doc/BRIEF.md
# CAN Message Buffer Flag Controller

This block keeps the control and status flags of a single CAN message buffer and decides, from those flags, whether the CAN protocol engine may send from the buffer or write a received message into it. A host processor reads and writes the flags through a six-bit register port. Each bit of that port has its own write strobe.

The protocol engine works through a few signals. It reads combinational eligibility outputs, asks for permission to store a message, and reports when a store or a transmission has completed. A controller-reset strobe clears the data-updated flag.

One flag, data-updated, changes its role with the direction bit:

- **Transmit buffer:** data-updated is an ordinary host-owned flag. It must be 1 before a data frame may go out.
- **Receive buffer:** the host may only clear data-updated. The engine sets it when a new message has been stored. When overwrite is disabled and the flag is set, further stores are refused.

Top module: `can_mbuf_ctrl`

## Requirements
- R1: After reset every flag reads 0. `tx_elig`, `rtr_elig`, `store_grant` and `store_rej` are all 0.
- R2: Flag register layout, used by both `host_wdata` and `host_rdata`: bit0 data-updated, bit1 transmit-request, bit2 ready, bit3 transmit-inhibit, bit4 direction (1 = transmit buffer), bit5 overwrite-enable. A host write updates exactly the bits whose `host_wstrb` bit is 1, and other bits keep their value.
- R3: With direction 1, a host write sets or clears data-updated as written.
- R4: With direction 0, a host write of 0 to data-updated clears it. A host write of 1 leaves it unchanged.
- R5: `tx_elig` is 1 exactly when direction, data-updated, ready and transmit-request are all 1 and transmit-inhibit is 0.
- R6: `rtr_elig` is 1 exactly when direction is 0 and ready and transmit-request are both 1, whatever transmit-inhibit and data-updated hold.
- R7: A one-cycle `store_req` is answered in the next cycle with a one-cycle pulse on exactly one of two outputs, and changes no flag:
  - `store_grant` when direction is 0 and (overwrite-enable is 1 or data-updated is 0);
  - otherwise `store_rej`.
- R8: `eng_store_done` sets data-updated when direction is 0 and storing is allowed (as in R7). Otherwise it has no effect.
- R9: `eng_tx_done` with direction 1 clears transmit-request and leaves data-updated unchanged. If a host write to transmit-request happens in the same cycle, the host write wins.
- R10: If an engine set of data-updated and a host clear of it happen in the same cycle, the flag ends at 1.
- R11: `eng_crst` clears data-updated and takes priority over any set of it. The engine never clears data-updated by any other means.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write enable |
| host_wstrb | input | 6 | Per-bit write strobes |
| host_wdata | input | 6 | Host write data |
| host_rdata | output | 6 | Current flag values |
| store_req | input | 1 | Engine asks to store a received message |
| eng_store_done | input | 1 | Engine finished storing a message |
| eng_tx_done | input | 1 | Engine finished a successful transmission |
| eng_crst | input | 1 | Controller reset, clears data-updated |
| tx_elig | output | 1 | Data frame may be transmitted |
| rtr_elig | output | 1 | Remote-frame request may be transmitted |
| store_grant | output | 1 | One-cycle store permission pulse |
| store_rej | output | 1 | One-cycle store refusal pulse |

## Verification
The main sweep drives every one of the 64 flag combinations into the buffer and then checks the read-back value, both eligibility outputs and the response to a store request. This separates the transmit gating from the remote-request gating. It also shows which flags each output ignores, such as transmit-inhibit and data-updated for a remote request, and whether the overwrite rule depends on both overwrite-enable and data-updated.

Directed sequences then cover the write rules that depend on direction, partial strobes, and the three same-cycle collisions:
- engine set against host clear;
- transmit-done against a host write of transmit-request;
- controller-reset against an engine set.

Each collision is checked at the read port in the cycle after the event.

// File: rtl/can_mbuf_pkg.sv
package can_mbuf_pkg;
    localparam int FLAG_W = 6;

    localparam int B_DUPD = 0;
    localparam int B_TREQ = 1;
    localparam int B_RDY  = 2;
    localparam int B_INH  = 3;
    localparam int B_DIR  = 4;
    localparam int B_OVR  = 5;

    typedef struct packed {
        logic ovr_en;
        logic dir_tx;
        logic tx_inh;
        logic rdy;
        logic treq;
        logic dupd;
    } mbuf_flags_t;
endpackage

// File: rtl/mbuf_gate.sv
module mbuf_gate
    import can_mbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  mbuf_flags_t flags,
    output logic        tx_elig,
    output logic        rtr_elig,
    output logic        store_ok
);
    logic send_armed;

    always_comb begin
        send_armed = flags.rdy && flags.treq;
        tx_elig    = flags.dir_tx && send_armed && flags.dupd && !flags.tx_inh;
        rtr_elig   = !flags.dir_tx && send_armed;
        store_ok   = !flags.dir_tx && (flags.ovr_en || !flags.dupd);
    end

    // R5 R6
    property elig_excl_p;
        @(posedge clk) disable iff (!rst_n) !(tx_elig && rtr_elig);
    endproperty
    elig_excl_chk: assert property (elig_excl_p);

    // R8
    property store_rx_only_p;
        @(posedge clk) disable iff (!rst_n) store_ok |-> !tx_elig;
    endproperty
    store_rx_only_chk: assert property (store_rx_only_p);
endmodule

// File: rtl/mbuf_flags.sv
module mbuf_flags
    import can_mbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [FLAG_W-1:0] host_wstrb,
    input  logic [FLAG_W-1:0] host_wdata,
    input  logic              store_ok,
    input  logic              eng_store_done,
    input  logic              eng_tx_done,
    input  logic              eng_crst,
    output mbuf_flags_t       flags_q
);
    mbuf_flags_t       flags_d;
    logic [FLAG_W-1:0] cur_bits;
    logic [FLAG_W-1:0] nxt_bits;
    logic              host_treq_wr;
    logic              eng_set;

    always_comb begin
        cur_bits     = flags_q;
        nxt_bits     = cur_bits;
        host_treq_wr = host_we && host_wstrb[B_TREQ];
        eng_set      = eng_store_done && store_ok;

        if (host_we) begin
            for (int i = 0; i < FLAG_W; i++) begin
                if (host_wstrb[i]) begin
                    if (i == B_DUPD && !flags_q.dir_tx) begin
                        if (!host_wdata[i]) nxt_bits[i] = 1'b0;
                    end else begin
                        nxt_bits[i] = host_wdata[i];
                    end
                end
            end
        end

        if (eng_tx_done && flags_q.dir_tx && !host_treq_wr)
            nxt_bits[B_TREQ] = 1'b0;

        if (eng_set)
            nxt_bits[B_DUPD] = 1'b1;

        if (eng_crst)
            nxt_bits[B_DUPD] = 1'b0;

        flags_d = nxt_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // R11
    property dupd_clear_src_p;
        @(posedge clk) disable iff (!rst_n)
            $fell(flags_q.dupd) |->
            $past(eng_crst || (host_we && host_wstrb[B_DUPD] && !host_wdata[B_DUPD]));
    endproperty
    dupd_clear_src_chk: assert property (dupd_clear_src_p);

    // R4
    property rx_no_host_set_p;
        @(posedge clk) disable iff (!rst_n)
            (!flags_q.dir_tx && !flags_q.dupd && !eng_store_done && host_we) |=> !flags_q.dupd;
    endproperty
    rx_no_host_set_chk: assert property (rx_no_host_set_p);

    // R10
    property eng_set_wins_p;
        @(posedge clk) disable iff (!rst_n)
            (eng_store_done && store_ok && !eng_crst) |=> flags_q.dupd;
    endproperty
    eng_set_wins_chk: assert property (eng_set_wins_p);

    // R9
    property txdone_clr_p;
        @(posedge clk) disable iff (!rst_n)
            (eng_tx_done && flags_q.dir_tx && !(host_we && host_wstrb[B_TREQ])) |=> !flags_q.treq;
    endproperty
    txdone_clr_chk: assert property (txdone_clr_p);
endmodule

// File: rtl/mbuf_resp.sv
module mbuf_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic store_req,
    input  logic store_ok,
    output logic store_grant,
    output logic store_rej
);
    typedef struct packed {
        logic grant;
        logic rej;
    } resp_t;

    resp_t resp_d, resp_q;

    always_comb begin
        resp_d.grant = store_req && store_ok;
        resp_d.rej   = store_req && !store_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign store_grant = resp_q.grant;
    assign store_rej   = resp_q.rej;

    // R7
    property resp_excl_p;
        @(posedge clk) disable iff (!rst_n) !(store_grant && store_rej);
    endproperty
    resp_excl_chk: assert property (resp_excl_p);

    // R7
    property resp_after_req_p;
        @(posedge clk) disable iff (!rst_n) (store_grant || store_rej) |-> $past(store_req);
    endproperty
    resp_after_req_chk: assert property (resp_after_req_p);
endmodule

// File: rtl/can_mbuf_ctrl.sv
module can_mbuf_ctrl
    import can_mbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [FLAG_W-1:0] host_wstrb,
    input  logic [FLAG_W-1:0] host_wdata,
    output logic [FLAG_W-1:0] host_rdata,
    input  logic              store_req,
    input  logic              eng_store_done,
    input  logic              eng_tx_done,
    input  logic              eng_crst,
    output logic              tx_elig,
    output logic              rtr_elig,
    output logic              store_grant,
    output logic              store_rej
);
    mbuf_flags_t flags;
    logic        store_ok;

    mbuf_flags u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_we        (host_we),
        .host_wstrb     (host_wstrb),
        .host_wdata     (host_wdata),
        .store_ok       (store_ok),
        .eng_store_done (eng_store_done),
        .eng_tx_done    (eng_tx_done),
        .eng_crst       (eng_crst),
        .flags_q        (flags)
    );

    mbuf_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (flags),
        .tx_elig  (tx_elig),
        .rtr_elig (rtr_elig),
        .store_ok (store_ok)
    );

    mbuf_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_req   (store_req),
        .store_ok    (store_ok),
        .store_grant (store_grant),
        .store_rej   (store_rej)
    );

    assign host_rdata = flags;

    // R2
    property rd_stable_idle_p;
        @(posedge clk) disable iff (!rst_n)
            (!host_we && !eng_store_done && !eng_tx_done && !eng_crst) |=> $stable(host_rdata);
    endproperty
    rd_stable_idle_chk: assert property (rd_stable_idle_p);
endmodule

// File: tb/sim_can_mbuf_ctrl.sv
module sim_can_mbuf_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [5:0] host_wstrb = '0;
    logic [5:0] host_wdata = '0;
    logic [5:0] host_rdata;
    logic       store_req = 1'b0;
    logic       eng_store_done = 1'b0;
    logic       eng_tx_done = 1'b0;
    logic       eng_crst = 1'b0;
    logic       tx_elig, rtr_elig, store_grant, store_rej;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    can_mbuf_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wstrb(host_wstrb),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .store_req(store_req),
        .eng_store_done(eng_store_done), .eng_tx_done(eng_tx_done), .eng_crst(eng_crst),
        .tx_elig(tx_elig), .rtr_elig(rtr_elig), .store_grant(store_grant), .store_rej(store_rej)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [5:0] strb, input logic [5:0] data);
        @(negedge clk);
        host_we = 1'b1; host_wstrb = strb; host_wdata = data;
        @(negedge clk);
        host_we = 1'b0; host_wstrb = '0; host_wdata = '0;
    endtask

    task automatic load(input logic [5:0] s);
        hwr(6'b010000, 6'b010000);
        hwr(6'b111111, s | 6'b010000);
        hwr(6'b010000, s);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 flags", {2'b0, host_rdata}, 8'h00);
        check("R1 outputs", {4'b0, tx_elig, rtr_elig, store_grant, store_rej}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // exhaustive sweep over all flag combinations
        for (int s = 0; s < 64; s++) begin
            logic [5:0] v;
            logic dupd, treq, rdy, inh, dir, ovr, ok;
            v = s[5:0];
            {ovr, dir, inh, rdy, treq, dupd} = v;
            load(v);
            check("R2 R3 readback", {2'b0, host_rdata}, {2'b0, v});
            check("R5 tx_elig", {7'b0, tx_elig}, {7'b0, dir & dupd & rdy & treq & ~inh});
            check("R6 rtr_elig", {7'b0, rtr_elig}, {7'b0, ~dir & rdy & treq});
            ok = ~dir & (ovr | ~dupd);
            store_req = 1'b1;
            @(negedge clk);
            store_req = 1'b0;
            check("R7 response", {6'b0, store_grant, store_rej}, {6'b0, ok, ~ok});
            check("R7 flags kept", {2'b0, host_rdata}, {2'b0, v});
            @(negedge clk);
            check("R7 pulse width", {6'b0, store_grant, store_rej}, 8'h00);
        end

        // R4: rx-mode host write of 1 ignored, write of 0 clears
        load(6'b000000);
        hwr(6'b000001, 6'b000001);
        check("R4 set ignored", {2'b0, host_rdata}, 8'h00);
        load(6'b000001);
        hwr(6'b000001, 6'b000000);
        check("R4 clear", {2'b0, host_rdata}, 8'h00);

        // R2 partial strobe
        load(6'b010110);
        hwr(6'b000100, 6'b111011);
        check("R2 partial strobe", {2'b0, host_rdata}, 8'h12);

        // R9 tx done clears request only
        load(6'b010111);
        @(negedge clk); eng_tx_done = 1'b1; @(negedge clk); eng_tx_done = 1'b0;
        check("R9 tx done", {2'b0, host_rdata}, 8'h15);
        // R9 host write of request wins
        load(6'b010111);
        @(negedge clk);
        eng_tx_done = 1'b1; host_we = 1'b1; host_wstrb = 6'b000010; host_wdata = 6'b000010;
        @(negedge clk);
        eng_tx_done = 1'b0; host_we = 1'b0; host_wstrb = '0; host_wdata = '0;
        check("R9 host wins", {2'b0, host_rdata}, 8'h17);
        // R9 ignored in rx mode
        load(6'b000110);
        @(negedge clk); eng_tx_done = 1'b1; @(negedge clk); eng_tx_done = 1'b0;
        check("R9 rx ignored", {2'b0, host_rdata}, 8'h06);

        // R8 store done sets data-updated in rx
        load(6'b000000);
        @(negedge clk); eng_store_done = 1'b1; @(negedge clk); eng_store_done = 1'b0;
        check("R8 set", {2'b0, host_rdata}, 8'h01);
        // R8 ignored in tx mode
        load(6'b010000);
        @(negedge clk); eng_store_done = 1'b1; @(negedge clk); eng_store_done = 1'b0;
        check("R8 tx ignored", {2'b0, host_rdata}, 8'h10);

        // R10 engine set beats host clear
        load(6'b100001);
        @(negedge clk);
        eng_store_done = 1'b1; host_we = 1'b1; host_wstrb = 6'b000001; host_wdata = 6'b0;
        @(negedge clk);
        eng_store_done = 1'b0; host_we = 1'b0; host_wstrb = '0;
        check("R10 collision", {2'b0, host_rdata}, 8'h21);

        // R11 controller reset clears and beats engine set
        load(6'b010001);
        @(negedge clk); eng_crst = 1'b1; @(negedge clk); eng_crst = 1'b0;
        check("R11 crst clears", {2'b0, host_rdata}, 8'h10);
        load(6'b100000);
        @(negedge clk);
        eng_crst = 1'b1; eng_store_done = 1'b1;
        @(negedge clk);
        eng_crst = 1'b0; eng_store_done = 1'b0;
        check("R11 crst priority", {2'b0, host_rdata}, 8'h20);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule